// File: doc/BRIEF.md
# Dual-Target Interrupt Mask Controller

This block drives one interrupt line toward each of two processor sites. Each site owns a mask register with two enable bits. One bit lets a shared bus-error event reach that site. The other bit raises a software interrupt directly. The bus-error event is held in a single sticky flag that both sites share. The flag can only be captured while at least one site enables bus errors. It is released only once neither site enables them.

Software reaches the block through a synchronous word-addressed port with a 3-bit address and 32-bit data. The port also holds four general-purpose read/write words, a live status word and one reserved location. A site's interrupt stays silent until that site pulses its acknowledge input once. After that pulse the site stays armed until reset.

Top module: `dimc_top`

## Requirements
- R1: After a synchronous active-high reset, every register, the bus-error flag, both arm flags and both interrupt outputs are 0, and every address reads 0.
- R2: Address 0 is site 0's mask word and address 1 is site 1's. In each, bit 8 is the bus-error enable and bit 0 is the software enable, both read/write. Bits 31..9 and 7..1 always read 0, and writes to them are discarded.
- R3: When `bus_err` is high at a clock edge and at least one site's bus-error enable is 1, the flag is 1 after that edge. With both enables 0, a `bus_err` pulse leaves the flag at 0.
- R4: The flag stays set while either bus-error enable is 1. It becomes 0 at the first edge at which both enables are 0.
- R5: `irq[s]` stays 0 until `site_ack[s]` has been high at a clock edge. From then on the site stays armed until reset.
- R6: `irq[s]` is a register. After each edge it equals armed_s AND ((bus-error enable_s AND flag) OR software enable_s), taken from the state before that edge. As a result it follows an arming or a flag change one cycle later.
- R7: Address 4 is read-only status. Bit 0 is the flag, bit 1 is `irq[0]`, bit 2 is `irq[1]`, and all other bits are 0. Writes to address 4 have no effect.
- R8: Addresses 2, 3, 5 and 6 are independent 32-bit read/write storage words.
- R9: Address 7 always reads 0, and writes to it change nothing readable.
- R10: `bus_rdata` is registered. After each edge it holds the word selected by `bus_addr` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | input | 1 | Bus-error event, sampled each edge |
| site_ack | input | 2 | Acknowledge access per site, arms that site |
| irq | output | 2 | Registered interrupt line per site |

## Verification
On every cycle, the assertions check these behaviours:
- the capture and release conditions of the bus-error flag;
- that an unarmed site stays quiet and that arming never drops;
- that each enabled source fires its site's line on the next edge;
- that the read-only bits, the status upper bits and the reserved word read zero.

Only the bench's scenarios can show the following:
- the address decode, meaning which word each address reaches;
- that the general-purpose words store distinct values;
- that writes to status or reserved locations leave everything else intact;
- the exact one-cycle latency of arming seen at the ports;
- the joint hand-over of the flag between sites.

// File: rtl/dimc_pkg.sv
package dimc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NSITE   = 2;
  localparam int BE_BIT  = 8;
  localparam int SW_BIT  = 0;
  localparam int NUM_GP  = 4;

  localparam logic [ADDR_W-1:0] ADR_STATUS   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RESERVED = 3'd7;
  localparam logic [ADDR_W-1:0] GP_ADR [NUM_GP] = '{3'd2, 3'd3, 3'd5, 3'd6};

  // Builds a mask word with only the two enable bits populated.
  function automatic logic [DATA_W-1:0] mask_word(input logic be, input logic sw);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BE_BIT] = be;
    w[SW_BIT] = sw;
    return w;
  endfunction
endpackage

// File: rtl/dimc_regfile.sv
module dimc_regfile
  import dimc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NS = NSITE,
  parameter int NG = NUM_GP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [NS-1:0] be_en,
  output logic [NS-1:0] sw_en,
  output logic [DW-1:0] gp_rdata,
  output logic          gp_hit
);
  logic [DW-1:0] gp_q [NG];

  // Site mask words live at addresses 0..NS-1.
  always_ff @(posedge clk) begin
    if (rst) begin
      be_en <= '0;
      sw_en <= '0;
    end else if (we) begin
      for (int s = 0; s < NS; s++) begin
        if (addr == AW'(s)) begin
          be_en[s] <= wdata[BE_BIT];
          sw_en[s] <= wdata[SW_BIT];
        end
      end
    end
  end

  // Plain storage words.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) gp_q[g] <= '0;
    end else if (we) begin
      for (int g = 0; g < NG; g++) begin
        if (addr == GP_ADR[g]) gp_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    gp_rdata = '0;
    gp_hit   = 1'b0;
    for (int g = 0; g < NG; g++) begin
      if (addr == GP_ADR[g]) begin
        gp_rdata = gp_q[g];
        gp_hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dimc_be_latch.sv
module dimc_be_latch #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_in,
  input  logic [NS-1:0] be_en,
  output logic          flag
);
  logic any_en;
  assign any_en = |be_en;

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (!any_en) flag <= 1'b0;
    else if (err_in)  flag <= 1'b1;
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (any_en && err_in) |=> flag);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!flag && !err_in) |=> !flag);
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (be_en == '0) |=> !flag);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && any_en) |=> flag);
endmodule

// File: rtl/dimc_site.sv
module dimc_site (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  logic be_en,
  input  logic sw_en,
  input  logic flag,
  output logic irq
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst)      armed <= 1'b0;
    else if (ack) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= armed & ((be_en & flag) | sw_en);
  end

  a_r5_quiet_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !irq);
  a_r5_arm_sticky: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
  a_r6_sw_fires: assert property (@(posedge clk) disable iff (rst)
    (armed && sw_en) |=> irq);
  a_r6_be_fires: assert property (@(posedge clk) disable iff (rst)
    (armed && be_en && flag) |=> irq);
endmodule

// File: rtl/dimc_top.sv
module dimc_top
  import dimc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  input  logic [NSITE-1:0]  site_ack,
  output logic [NSITE-1:0]  irq
);
  logic [NSITE-1:0]  be_en, sw_en;
  logic [DATA_W-1:0] gp_rdata, rd_next;
  logic              gp_hit, be_flag;

  dimc_regfile #(.DW(DATA_W), .AW(ADDR_W), .NS(NSITE), .NG(NUM_GP)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .be_en(be_en), .sw_en(sw_en), .gp_rdata(gp_rdata), .gp_hit(gp_hit)
  );

  dimc_be_latch #(.NS(NSITE)) u_latch (
    .clk(clk), .rst(rst), .err_in(bus_err), .be_en(be_en), .flag(be_flag)
  );

  for (genvar s = 0; s < NSITE; s++) begin : g_site
    dimc_site u_site (
      .clk(clk), .rst(rst), .ack(site_ack[s]), .be_en(be_en[s]),
      .sw_en(sw_en[s]), .flag(be_flag), .irq(irq[s])
    );
  end

  always_comb begin
    rd_next = '0;
    if (gp_hit) rd_next = gp_rdata;
    else if (bus_addr == ADR_STATUS) begin
      rd_next[0]       = be_flag;
      rd_next[NSITE:1] = irq;
    end else begin
      for (int s = 0; s < NSITE; s++) begin
        if (bus_addr == ADDR_W'(s)) rd_next = mask_word(be_en[s], sw_en[s]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  a_r2_ro_bits_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) < ADDR_W'(NSITE)) |->
      (bus_rdata[DATA_W-1:BE_BIT+1] == '0 && bus_rdata[BE_BIT-1:SW_BIT+1] == '0));
  a_r7_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADR_STATUS) |-> (bus_rdata[DATA_W-1:NSITE+1] == '0));
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADR_RESERVED) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_dimc_top.sv
`timescale 1ns/1ps
module tb_dimc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err = 1'b0;
  logic [1:0]  site_ack = '0;
  logic [1:0]  irq;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dimc_top dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .site_ack(site_ack), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_err();
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
  endtask

  task automatic pulse_ack(input int s);
    @(negedge clk); site_ack[s] = 1'b1;
    @(negedge clk); site_ack[s] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_mask_fields();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R2 site0 mask bits", d, 32'h0000_0101);
    wr(3'd1, 32'h0000_0100);
    rd(3'd1, d); check("R2 site1 mask bits", d, 32'h0000_0100);
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'hFFFF_FEFE);
    rd(3'd1, d); check("R2 ro bits ignored", d, 32'h0);
    rd(3'd0, d); check("R2 site0 cleared", d, 32'h0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(3'd2, 32'hA5A5_0001);
    wr(3'd3, 32'h5A5A_0002);
    wr(3'd5, 32'hDEAD_0005);
    wr(3'd6, 32'hBEEF_0006);
    rd(3'd2, d); check("R8 word2", d, 32'hA5A5_0001);
    rd(3'd3, d); check("R10 next addr word3", d, 32'h5A5A_0002);
    rd(3'd5, d); check("R8 word5", d, 32'hDEAD_0005);
    rd(3'd6, d); check("R8 word6", d, 32'hBEEF_0006);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d); check("R9 reserved reads zero", d, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R7 status write ignored", d, 32'h0);
    rd(3'd0, d); check("R9 mask untouched", d, 32'h0);
    rd(3'd2, d); check("R9 word2 untouched", d, 32'hA5A5_0001);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    pulse_err(); idle(2);
    rd(3'd4, d); check("R3 no latch unmasked", d, 32'h0);
    wr(3'd0, 32'h100);
    pulse_err(); idle(2);
    rd(3'd4, d); check("R3 latch with site0 enable", d[0], 32'h1);
    wr(3'd1, 32'h100);
    wr(3'd0, 32'h000); idle(2);
    rd(3'd4, d); check("R4 hold while site1 enabled", d[0], 32'h1);
    wr(3'd1, 32'h000); idle(2);
    rd(3'd4, d); check("R4 release when both clear", d[0], 32'h0);
  endtask

  task automatic t_arm();
    logic [31:0] d;
    wr(3'd0, 32'h001); idle(3);
    check("R5 unarmed quiet", {30'b0, irq}, 32'h0);
    pulse_ack(0);
    check("R6 one-cycle latency", {31'b0, irq[0]}, 32'h0);
    @(negedge clk);
    check("R6 sw irq site0", {30'b0, irq}, 32'h1);
    wr(3'd0, 32'h100); idle(2);
    check("R6 be path needs flag", {30'b0, irq}, 32'h0);
    pulse_err(); idle(2);
    check("R6 be irq site0", {30'b0, irq}, 32'h1);
    wr(3'd1, 32'h100); idle(2);
    check("R5 site1 still unarmed", {31'b0, irq[1]}, 32'h0);
    pulse_ack(1); idle(2);
    check("R6 be irq site1", {30'b0, irq}, 32'h3);
    rd(3'd4, d); check("R7 status all set", d, 32'h7);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); idle(2);
    check("R4 clear drops irq", {30'b0, irq}, 32'h0);
    rd(3'd4, d); check("R7 status clear", d, 32'h0);
    idle(10);
    wr(3'd1, 32'h001); idle(2);
    check("R5 arm sticky site1", {30'b0, irq}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask_fields();
    t_storage();
    t_latch();
    t_arm();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule